// File: doc/BRIEF.md
# Dual-precision signed array multiplier

This block multiplies two signed two's-complement operands with a regular array of AND-gate partial products and full-adder rows. It does not sign-extend the operands. Partial products that pair a sign bit with a magnitude bit are inverted, and a fixed correction constant seeds the accumulation, so the array contains adders only. By default it forms a 32-bit product from two 16-bit operands.

A precision input switches the array to 8-bit operation. In that mode only the cells fed by the low operand byte are enabled, and the sign-bit complement pattern moves to bit 7. The low 16 product bits come directly from the array. A multiplexer after the last adder row fills bits 31:16 with the sign of the 16-bit result. The product can be registered once, with a valid flag that travels alongside it.

Top module: `bw_mult`

## Requirements
- R1: With `half_mode` low, `prod` equals the signed product of `op_a` and `op_b` as 32-bit two's complement.
- R2: In full mode the most negative operand is handled: -32768 times -32768 gives 0x40000000, and -32768 times 32767 gives 0xC0008000.
- R3: With `half_mode` high, `prod[15:0]` equals the signed product of `op_a[7:0]` and `op_b[7:0]`.
- R4: With `half_mode` high, every bit of `prod[31:16]` equals `prod[15]`.
- R5: With `half_mode` high, `op_a[15:8]` and `op_b[15:8]` have no effect on `prod`.
- R6: In half mode -128 times -128 gives 0x00004000, and -128 times 127 gives 0xFFFFC080.
- R7: With the output register present, which is the default, `prod` and `out_valid` show the result of the inputs sampled at a rising clock edge right after that edge. `out_valid` is a one-cycle-delayed copy of `in_valid`.
- R8: While `rst_n` is low, `prod` is 0 and `out_valid` is 0.
- R9: A zero operand gives a zero product in both modes, whatever the other operand is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands are valid this cycle |
| half_mode | input | 1 | 1 selects the 8-bit multiply of the low bytes |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier |
| prod | output | 32 | Signed product |
| out_valid | output | 1 | `prod` holds a valid result |

## Verification
A vector table pairs each mode with every sign combination. Mixed signs expose a wrong complemented-term pattern or a wrong correction constant, and the extreme negative values expose an error in the constant's top bit. Half-mode vectors with non-zero upper bytes separate correct gating of the unused cells from leakage into the result. Random operands in both modes then stress carry propagation across all adder rows, and toggling the valid flag confirms the one-cycle alignment of result and flag.

// File: rtl/bw_mult.sv
module bw_mult #(
  parameter int W       = 16,
  parameter int HW      = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            half_mode,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  output logic [2*W-1:0]  prod,
  output logic            out_valid
);
  localparam int PW = 2 * W;
  localparam int HP = 2 * HW;
  localparam logic [PW-1:0] CORR_F = (PW'(1) << W)  | (PW'(1) << (PW - 1));
  localparam logic [PW-1:0] CORR_H = (PW'(1) << HW) | (PW'(1) << (HP - 1));

  function automatic logic [PW-1:0] fa_row(input logic [PW-1:0] x, input logic [PW-1:0] y);
    logic [PW-1:0] s;
    logic c;
    c = 1'b0;
    for (int k = 0; k < PW; k++) begin
      s[k] = x[k] ^ y[k] ^ c;
      c    = (x[k] & y[k]) | (x[k] & c) | (y[k] & c);
    end
    return s;
  endfunction

  genvar i, j;
  generate
    for (i = 0; i < W; i++) begin : g_row
      logic [W-1:0]  pp;
      logic [PW-1:0] sum;
      for (j = 0; j < W; j++) begin : g_cell
        localparam bit INV_F = (i == W - 1) != (j == W - 1);
        localparam bit INV_H = (i == HW - 1) != (j == HW - 1);
        localparam bit EN_H  = (i < HW) && (j < HW);
        logic en, inv;
        assign en    = half_mode ? EN_H : 1'b1;
        assign inv   = half_mode ? INV_H : INV_F;
        assign pp[j] = en & ((op_a[j] & op_b[i]) ^ inv);
      end
      if (i == 0) begin : g_first
        assign sum = fa_row(half_mode ? CORR_H : CORR_F, {{W{1'b0}}, pp});
      end else begin : g_next
        assign sum = fa_row(g_row[i-1].sum, {{W{1'b0}}, pp} << i);
      end
    end
  endgenerate

  logic [PW-1:0] raw, sel;
  assign raw = g_row[W-1].sum;
  assign sel = half_mode ? {{(PW-HP){raw[HP-1]}}, raw[HP-1:0]} : raw;

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prod      <= '0;
          out_valid <= 1'b0;
        end else begin
          prod      <= sel;
          out_valid <= in_valid;
        end
      end

      AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
      AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
      AST_HALF_SIGNEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(half_mode)) |-> (prod[PW-1:HP] == {(PW-HP){prod[HP-1]}})); // R4
      AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_a) == '0) |-> (prod == '0)); // R9
      AST_MOST_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(half_mode) &&
         $past(op_a) == (W'(1) << (W-1)) && $past(op_b) == (W'(1) << (W-1)))
        |-> (prod == (PW'(1) << (PW-2)))); // R2
    end else begin : g_comb
      assign prod      = sel;
      assign out_valid = in_valid;
    end
  endgenerate
endmodule

// File: tb/sim_bw_mult.sv
module sim_bw_mult;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic half_mode = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [31:0] prod;
  logic out_valid;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bw_mult u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .half_mode(half_mode),
              .op_a(op_a), .op_b(op_b), .prod(prod), .out_valid(out_valid));

  // {half_mode, op_a, op_b}
  localparam logic [32:0] VEC [16] = '{
    {1'b0, 16'h0003, 16'h0005}, {1'b0, 16'hFFFD, 16'h0005},
    {1'b0, 16'h0003, 16'hFFFB}, {1'b0, 16'hFFFD, 16'hFFFB},
    {1'b0, 16'h8000, 16'h8000}, {1'b0, 16'h8000, 16'h7FFF},
    {1'b0, 16'h7FFF, 16'h7FFF}, {1'b0, 16'h0000, 16'h8001},
    {1'b1, 16'h0007, 16'h0009}, {1'b1, 16'h00F9, 16'h0009},
    {1'b1, 16'h0007, 16'h00F7}, {1'b1, 16'h00F9, 16'h00F7},
    {1'b1, 16'h0080, 16'h0080}, {1'b1, 16'h0080, 16'h007F},
    {1'b1, 16'h007F, 16'h007F}, {1'b1, 16'h0000, 16'h0081}
  };

  function automatic logic [31:0] model(input logic m, input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] p;
    if (m) p = 32'(signed'(a[7:0]) * signed'(b[7:0]));
    else   p = signed'(a) * signed'(b);
    return p;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic m, input logic [15:0] a, input logic [15:0] b);
    half_mode = m; op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 prod in reset", prod, 32'h0);
    chk("R8 valid in reset", {31'b0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      apply(VEC[i][32], VEC[i][31:16], VEC[i][15:0]);
      chk(VEC[i][32] ? "R3 table" : "R1 table", prod, model(VEC[i][32], VEC[i][31:16], VEC[i][15:0]));
    end

    apply(1'b0, 16'h8000, 16'h8000); chk("R2 min*min", prod, 32'h40000000);
    apply(1'b0, 16'h8000, 16'h7FFF); chk("R2 min*max", prod, 32'hC0008000);
    apply(1'b1, 16'h0080, 16'h0080); chk("R6 min*min", prod, 32'h00004000);
    apply(1'b1, 16'h0080, 16'h007F); chk("R6 min*max", prod, 32'hFFFFC080);
    apply(1'b1, 16'hA503, 16'h7FFD); chk("R5 upper bytes ignored", prod, 32'hFFFFFFF7);
    apply(1'b1, 16'h5A83, 16'hC301); chk("R5 upper bytes ignored", prod, 32'hFFFFFF83);
    apply(1'b1, 16'hFF00, 16'h1234); chk("R9 half zero", prod, 32'h0);
    apply(1'b0, 16'h0000, 16'hFFFF); chk("R9 full zero", prod, 32'h0);
    apply(1'b1, 16'h00FF, 16'h0001);
    chk("R4 sign ext", {16'h0, prod[31:16]}, {16'h0, {16{prod[15]}}});
    chk("R7 valid high", {31'b0, out_valid}, 32'h1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 valid low", {31'b0, out_valid}, 32'h0);

    for (int i = 0; i < 400; i++) begin
      logic m;
      logic [15:0] a, b;
      m = 1'(i & 1); a = 16'($urandom); b = 16'($urandom);
      apply(m, a, b);
      chk(m ? "R3 random" : "R1 random", prod, model(m, a, b));
      if (m) chk("R4 random", {16'h0, prod[31:16]}, {16'h0, {16{prod[15]}}});
    end
    in_valid = 1'b0;

    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 reset clears", prod, 32'h0);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=%0d exp=done", cyc);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule